// File: doc/BRIEF.md
# Processor Power Mode Manager

This block decides which power mode a processor core is in and drives the three signals that put the core there: a core clock enable, a core reset hold and the enable pin of the external main supply. It runs on a slow always-on clock, so it keeps working while the core is unpowered. There are three modes. In run mode the core works normally. In idle mode only the core clock is gated. Timers, interrupt logic, GPIO and this manager keep their clocks. In sleep mode the core is held in reset and the main supply is switched off.

Software asks for idle with a one-cycle request and asks for sleep by writing a sleep bit. Either of two supply-fault flags forces sleep without software. Going to sleep takes a timed three-step shutdown. Leaving sleep needs a wake event and takes a three-step restart: the supply comes up and settles, the block waits for the oscillator, and then the core reset is released. Each step length is a count of always-on clock cycles, worked out from the clock rate and a time in microseconds. A status output reports the current mode and a sticky record of why sleep was entered. Software clears that record by writing ones to it.

Top module: `pwr_mode_mgr`

## Requirements
- R1: After a synchronous active-low reset, the block is in run mode with `core_clk_en`=1, `core_rst`=0, `supply_en`=1 and `stat_cause`=0.
- R2: In run mode, with no sleep source active, `idle_req` moves the block to idle on the next clock edge. Idle sets `core_clk_en`=0 and leaves `core_rst`=0 and `supply_en`=1.
- R3: In idle mode, `irq` or `ext_reset` returns the block to run with `core_clk_en`=1 on the next clock edge.
- R4: In run or idle, `sleep_set`, `vdd_flt` or `batt_flt` starts the shutdown. A sleep source wins over `idle_req` and `irq` in the same cycle. Step 1 has the clock gated, the core out of reset and the supply on. Step 2 adds the core reset. Step 3 also drops `supply_en`. After step 3 the block is in sleep.
- R5: Sleep lasts until `wake_evt`. `irq`, `idle_req`, `sleep_set`, `ext_reset` and the fault flags have no effect while asleep.
- R6: Wake-up raises `supply_en` with `core_rst`=1 for WK cycles, then waits for `osc_ready`, then returns to run with `core_rst`=0 and `core_clk_en`=1. The core reset is never released while the clock is enabled.
- R7: During shutdown and during wake-up, `idle_req`, `sleep_set`, `irq` and `ext_reset` are ignored.
- R8: A fault flag seen during either wake-up step aborts the wake-up. The shutdown restarts at step 1 on the next edge, and the fault is recorded as a cause.
- R9: `stat_cause` bit 0 records software, bit 1 the main-supply fault and bit 2 the battery fault. Each bit is set when sleep entry is triggered, one cycle later. A bit stays set until software writes 1 to the same bit of `cause_clr`. A set in the same cycle wins over the clear.
- R10: `stat_mode` encodes 0 run, 1 idle, 2 shutting down, 3 sleep and 4 waking.
- R11: Each shutdown step lasts SD = ceil(CLK_HZ·SD_US/10^6) cycles, with a minimum of 1. The first wake-up step lasts WK = ceil(CLK_HZ·WK_US/10^6) cycles, with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on low-speed clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| idle_req | input | 1 | Software request for idle mode |
| sleep_set | input | 1 | Software write of the sleep bit |
| irq | input | 1 | Interrupt from an internal unit or a peripheral |
| ext_reset | input | 1 | External reset request; ends idle |
| wake_evt | input | 1 | Preprogrammed wake-up event |
| vdd_flt | input | 1 | Main supply out of regulation |
| batt_flt | input | 1 | Battery low or removed |
| osc_ready | input | 1 | Main oscillator has reached speed |
| cause_clr | input | 3 | Write-one-to-clear for the cause bits |
| core_clk_en | output | 1 | Core clock enable |
| core_rst | output | 1 | Core reset hold, active high |
| supply_en | output | 1 | Main supply enable pin |
| stat_mode | output | 3 | Current mode code |
| stat_cause | output | 3 | Sticky sleep-entry causes |

## Verification
Several stimulus patterns are used, and each one separates a different kind of fault. Leaving idle by interrupt and leaving it by external reset show that both exits are present. Sending an idle request together with the sleep bit shows whether the sleep source has priority. Pulses on every request line during shutdown and during sleep show that these states ignore them. One wake-up runs clean and one is aborted by a battery fault, which shows the abort path, the restart of the shutdown and the recorded cause. The cause field is cleared once on its own and once in the same cycle as a new fault, which shows that a new set beats a clear. A reset taken while asleep shows that the power-on state is restored from any mode.

// File: rtl/pmm_pkg.sv
// Package: shared encodings for the power mode manager.
// Assumes: no other package defines these names.
package pmm_pkg;

    // Mode code reported on the status output
    typedef enum logic [2:0] {
        MODE_RUN   = 3'd0,
        MODE_IDLE  = 3'd1,
        MODE_SHUT  = 3'd2,
        MODE_SLEEP = 3'd3,
        MODE_WAKE  = 3'd4
    } pmm_mode_e;

    // Internal sequencing state
    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_IDLE  = 3'd1,
        ST_SD1   = 3'd2,
        ST_SD2   = 3'd3,
        ST_SD3   = 3'd4,
        ST_SLEEP = 3'd5,
        ST_WK1   = 3'd6,
        ST_WK2   = 3'd7
    } pmm_state_e;

    // Bit positions of the cause field
    localparam int CAUSE_SW   = 0;
    localparam int CAUSE_VDD  = 1;
    localparam int CAUSE_BATT = 2;
    localparam int CAUSE_W    = 3;

    // Step length in cycles, rounded up, never below one
    function automatic int step_cycles(input longint hz, input longint us);
        longint c;
        c = (hz * us + 64'd999999) / 64'd1000000;
        return (c < 1) ? 1 : int'(c);
    endfunction

endpackage

// File: rtl/pmm_step_timer.sv
// Module: down-counter that times the steps of a sequence.
// Assumes: load has priority; done is high while the count is zero.
module pmm_step_timer #(
    parameter int LEN_SD = 1,
    parameter int LEN_WK = 1,
    parameter int W      = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic sel_wk,
    output logic done
);
    localparam logic [W-1:0] LOAD_SD = W'(LEN_SD - 1);
    localparam logic [W-1:0] LOAD_WK = W'(LEN_WK - 1);

    logic [W-1:0] cnt;

    // Count register: reload on request, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= sel_wk ? LOAD_WK : LOAD_SD;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // Step end flag
    assign done = (cnt == '0);
endmodule

// File: rtl/pmm_cause_reg.sv
// Module: sticky sleep-cause bits with write-one-to-clear.
// Assumes: a set in the same cycle as a clear wins.
module pmm_cause_reg #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic [W-1:0] set_bits,
    input  logic [W-1:0] clr,
    output logic [W-1:0] cause
);
    logic [W-1:0] set_v;

    // Gate the set vector with its strobe
    assign set_v = set_en ? set_bits : '0;

    // Sticky bits with clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            cause <= '0;
        else
            cause <= (cause & ~clr) | set_v;
    end
endmodule

// File: rtl/pmm_fsm.sv
// Module: mode sequencer for run, idle, shutdown, sleep and wake-up.
// Assumes: step_done comes from a timer that this FSM reloads on every timed entry.
module pmm_fsm
    import pmm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                idle_req,
    input  logic                sleep_set,
    input  logic                irq,
    input  logic                ext_reset,
    input  logic                wake_evt,
    input  logic                vdd_flt,
    input  logic                batt_flt,
    input  logic                osc_ready,
    input  logic                step_done,
    output logic                tmr_load,
    output logic                tmr_sel_wk,
    output logic                cause_set,
    output logic [CAUSE_W-1:0]  cause_bits,
    output logic                core_clk_en,
    output logic                core_rst,
    output logic                supply_en,
    output pmm_mode_e           mode
);
    pmm_state_e state, nxt;
    logic       fault, enter_req;

    assign fault     = vdd_flt | batt_flt;
    assign enter_req = fault | sleep_set;

    // Next-state and side-effect selection
    always_comb begin
        nxt        = state;
        tmr_load   = 1'b0;
        tmr_sel_wk = 1'b0;
        cause_set  = 1'b0;
        cause_bits = '0;
        unique case (state)
            ST_RUN, ST_IDLE: begin
                if (enter_req) begin
                    nxt                    = ST_SD1;
                    tmr_load               = 1'b1;
                    cause_set              = 1'b1;
                    cause_bits[CAUSE_SW]   = sleep_set;
                    cause_bits[CAUSE_VDD]  = vdd_flt;
                    cause_bits[CAUSE_BATT] = batt_flt;
                end else if (state == ST_RUN && idle_req) begin
                    nxt = ST_IDLE;
                end else if (state == ST_IDLE && (irq || ext_reset)) begin
                    nxt = ST_RUN;
                end
            end
            ST_SD1: if (step_done) begin
                nxt      = ST_SD2;
                tmr_load = 1'b1;
            end
            ST_SD2: if (step_done) begin
                nxt      = ST_SD3;
                tmr_load = 1'b1;
            end
            ST_SD3: if (step_done) nxt = ST_SLEEP;
            ST_SLEEP: if (wake_evt) begin
                nxt        = ST_WK1;
                tmr_load   = 1'b1;
                tmr_sel_wk = 1'b1;
            end
            ST_WK1, ST_WK2: begin
                if (fault) begin
                    nxt                    = ST_SD1;
                    tmr_load               = 1'b1;
                    cause_set              = 1'b1;
                    cause_bits[CAUSE_VDD]  = vdd_flt;
                    cause_bits[CAUSE_BATT] = batt_flt;
                end else if (state == ST_WK1 && step_done) begin
                    nxt = ST_WK2;
                end else if (state == ST_WK2 && osc_ready) begin
                    nxt = ST_RUN;
                end
            end
            default: nxt = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_RUN;
        else
            state <= nxt;
    end

    // Output decode from state
    always_comb begin
        core_clk_en = (state == ST_RUN);
        supply_en   = !(state == ST_SD3 || state == ST_SLEEP);
        core_rst    = (state == ST_SD2) || (state == ST_SD3) || (state == ST_SLEEP) ||
                      (state == ST_WK1) || (state == ST_WK2);
        unique case (state)
            ST_RUN:                 mode = MODE_RUN;
            ST_IDLE:                mode = MODE_IDLE;
            ST_SD1, ST_SD2, ST_SD3: mode = MODE_SHUT;
            ST_SLEEP:               mode = MODE_SLEEP;
            default:                mode = MODE_WAKE;
        endcase
    end
endmodule

// File: rtl/pwr_mode_mgr.sv
// Module: top of the power mode manager.
// Assumes: clk is the always-on slow clock at CLK_HZ; inputs are synchronous to it.
module pwr_mode_mgr
    import pmm_pkg::*;
#(
    parameter int CLK_HZ = 32768,
    parameter int SD_US  = 30,
    parameter int WK_US  = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                idle_req,
    input  logic                sleep_set,
    input  logic                irq,
    input  logic                ext_reset,
    input  logic                wake_evt,
    input  logic                vdd_flt,
    input  logic                batt_flt,
    input  logic                osc_ready,
    input  logic [2:0]          cause_clr,
    output logic                core_clk_en,
    output logic                core_rst,
    output logic                supply_en,
    output logic [2:0]          stat_mode,
    output logic [2:0]          stat_cause
);
    localparam int SD_CYC  = step_cycles(CLK_HZ, SD_US);
    localparam int WK_CYC  = step_cycles(CLK_HZ, WK_US);
    localparam int MAX_CYC = (SD_CYC > WK_CYC) ? SD_CYC : WK_CYC;
    localparam int TW      = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    logic                tmr_load, tmr_sel_wk, step_done, cause_set;
    logic [CAUSE_W-1:0]  cause_bits;
    pmm_mode_e           mode;

    pmm_step_timer #(.LEN_SD(SD_CYC), .LEN_WK(WK_CYC), .W(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .sel_wk(tmr_sel_wk), .done(step_done)
    );

    pmm_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .sleep_set(sleep_set),
        .irq(irq), .ext_reset(ext_reset), .wake_evt(wake_evt), .vdd_flt(vdd_flt),
        .batt_flt(batt_flt), .osc_ready(osc_ready), .step_done(step_done),
        .tmr_load(tmr_load), .tmr_sel_wk(tmr_sel_wk), .cause_set(cause_set),
        .cause_bits(cause_bits), .core_clk_en(core_clk_en), .core_rst(core_rst),
        .supply_en(supply_en), .mode(mode)
    );

    pmm_cause_reg #(.W(CAUSE_W)) u_cause (
        .clk(clk), .rst_n(rst_n), .set_en(cause_set), .set_bits(cause_bits),
        .clr(cause_clr), .cause(stat_cause)
    );

    assign stat_mode = mode;
endmodule

// File: rtl/pmm_checker.sv
// Module: temporal properties of the power mode manager, bound to the top.
// Assumes: mode codes as in the brief (0 run, 1 idle, 2 shut, 3 sleep, 4 wake).
module pmm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       irq,
    input logic       ext_reset,
    input logic       sleep_set,
    input logic       wake_evt,
    input logic       vdd_flt,
    input logic       batt_flt,
    input logic [2:0] cause_clr,
    input logic       core_clk_en,
    input logic       core_rst,
    input logic       supply_en,
    input logic [2:0] stat_mode,
    input logic [2:0] stat_cause
);
    // Clock enabled only in run mode
    p_clk_only_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        core_clk_en |-> stat_mode == 3'd0);

    // Idle exits to run on interrupt or reset when no sleep source is present
    p_idle_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_mode == 3'd1 && (irq || ext_reset) && !sleep_set && !vdd_flt && !batt_flt)
        |=> stat_mode == 3'd0);

    // Supply off only late in shutdown or asleep
    p_supply_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_en |-> (stat_mode == 3'd2 || stat_mode == 3'd3));

    // Sleep holds without a wake event
    p_sleep_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_mode == 3'd3 && !wake_evt) |=> stat_mode == 3'd3);

    // Wake event starts wake-up with supply on and core held in reset
    p_wake_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_mode == 3'd3 && wake_evt) |=> (stat_mode == 3'd4 && supply_en && core_rst));

    // Reset and clock never active together
    p_rst_no_clk_r6: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |-> !core_clk_en);

    // Fault during wake-up restarts shutdown
    p_wake_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_mode == 3'd4 && (vdd_flt || batt_flt)) |=> (stat_mode == 3'd2 && supply_en));

    // Cause bits only drop through a clear
    p_cause_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(stat_cause) & ~$past(cause_clr)) & ~stat_cause) == 3'b000));

    // Mode code always legal
    p_mode_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_mode <= 3'd4);
endmodule

bind pwr_mode_mgr pmm_checker u_pmm_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .ext_reset(ext_reset), .sleep_set(sleep_set),
    .wake_evt(wake_evt), .vdd_flt(vdd_flt), .batt_flt(batt_flt), .cause_clr(cause_clr),
    .core_clk_en(core_clk_en), .core_rst(core_rst), .supply_en(supply_en),
    .stat_mode(stat_mode), .stat_cause(stat_cause)
);

// File: tb/pwr_mode_mgr_bench.sv
// Bench: behavioural reference model compared on every clock, plus scenario checks.
module pwr_mode_mgr_bench;
    localparam int HZ = 200000;
    localparam int SDU = 30;
    localparam int WKU = 10;
    // Expected step lengths computed from R11: ceil(HZ*us/1e6)
    localparam int SDN = (HZ * SDU + 999999) / 1000000;
    localparam int WKN = (HZ * WKU + 999999) / 1000000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic idle_req = 0, sleep_set = 0, irq = 0, ext_reset = 0, wake_evt = 0;
    logic vdd_flt = 0, batt_flt = 0, osc_ready = 0;
    logic [2:0] cause_clr = 3'b000;
    logic core_clk_en, core_rst, supply_en;
    logic [2:0] stat_mode, stat_cause;

    int n_chk = 0, n_fail = 0, cyc = 0, osc_cnt = 0;
    bit started = 0;

    // model state: phase 0 run,1 idle,2..4 shutdown steps,5 sleep,6 wake1,7 wake2
    int m_ph = 0, m_cnt = 0;
    logic [2:0] m_cause = 3'b000;

    always #2.5 clk = ~clk;

    pwr_mode_mgr #(.CLK_HZ(HZ), .SD_US(SDU), .WK_US(WKU)) u_pwr_mode_mgr (
        .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .sleep_set(sleep_set), .irq(irq),
        .ext_reset(ext_reset), .wake_evt(wake_evt), .vdd_flt(vdd_flt), .batt_flt(batt_flt),
        .osc_ready(osc_ready), .cause_clr(cause_clr), .core_clk_en(core_clk_en),
        .core_rst(core_rst), .supply_en(supply_en), .stat_mode(stat_mode),
        .stat_cause(stat_cause)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Reference model update on each edge
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_cause = 3'b000;
        end else begin
            logic [2:0] setv;
            logic f;
            int nph;
            setv = 3'b000;
            f = vdd_flt | batt_flt;
            nph = m_ph;
            if (m_ph <= 1) begin
                if (f || sleep_set) begin
                    setv = {batt_flt, vdd_flt, sleep_set};
                    nph = 2; m_cnt = SDN;
                end else if (m_ph == 0 && idle_req) nph = 1;
                else if (m_ph == 1 && (irq || ext_reset)) nph = 0;
            end else if (m_ph >= 2 && m_ph <= 4) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    nph = m_ph + 1;
                    m_cnt = SDN;
                end
            end else if (m_ph == 5) begin
                if (wake_evt) begin nph = 6; m_cnt = WKN; end
            end else begin
                if (f) begin
                    setv = {batt_flt, vdd_flt, 1'b0};
                    nph = 2; m_cnt = SDN;
                end else if (m_ph == 6) begin
                    m_cnt--;
                    if (m_cnt == 0) nph = 7;
                end else if (osc_ready) nph = 0;
            end
            m_ph = nph;
            m_cause = (m_cause & ~cause_clr) | setv;
        end
    end

    // Compare every cycle, drive oscillator model, watchdog
    always @(negedge clk) begin
        cyc++;
        if (started) begin
            int em;
            em = (m_ph <= 1) ? m_ph : (m_ph <= 4) ? 2 : (m_ph == 5) ? 3 : 4;
            chk("R10 mode", stat_mode, em);
            chk("R2 clk_en", core_clk_en, (m_ph == 0) ? 1 : 0);
            chk("R6 core_rst", core_rst, (m_ph >= 3) ? 1 : 0);
            chk("R4 supply_en", supply_en, (m_ph == 4 || m_ph == 5) ? 0 : 1);
            chk("R9 cause", stat_cause, m_cause);
        end
        if (!supply_en) osc_cnt = 0;
        else if (osc_cnt < 5) osc_cnt++;
        osc_ready = (osc_cnt >= 5);
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
            report();
        end
    end

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_mode(input int m);
        while (stat_mode != m) @(negedge clk);
    endtask

    initial begin
        idle(3);
        rst_n = 1;
        idle(1);
        // R1: reset state
        chk("R1 mode", stat_mode, 0);
        chk("R1 clk_en", core_clk_en, 1);
        chk("R1 supply", supply_en, 1);
        chk("R1 core_rst", core_rst, 0);
        chk("R1 cause", stat_cause, 0);

        // R2 then R3 via irq
        idle_req = 1; idle(1); idle_req = 0;
        chk("R2 idle mode", stat_mode, 1);
        idle(3);
        irq = 1; idle(1); irq = 0;
        chk("R3 irq exit", stat_mode, 0);
        chk("R3 clk back", core_clk_en, 1);
        // R3 via external reset
        idle_req = 1; idle(1); idle_req = 0;
        ext_reset = 1; idle(1); ext_reset = 0;
        chk("R3 ext_reset exit", stat_mode, 0);

        // R4 priority over idle, and R11 length
        idle_req = 1; sleep_set = 1; idle(1); idle_req = 0; sleep_set = 0;
        chk("R4 priority", stat_mode, 2);
        begin
            int n;
            n = 0;
            while (stat_mode == 2 && n < 1000) begin n++; idle(1); end
            chk("R11 shutdown length", n, 3 * SDN);
        end
        // R5: ignore in sleep
        irq = 1; idle_req = 1; ext_reset = 1; vdd_flt = 1; sleep_set = 1;
        idle(2);
        irq = 0; idle_req = 0; ext_reset = 0; vdd_flt = 0; sleep_set = 0;
        chk("R5 stays asleep", stat_mode, 3);
        chk("R9 sw cause", stat_cause, 3'b001);
        // R6 wake
        wake_evt = 1; idle(1); wake_evt = 0;
        chk("R6 supply on", supply_en, 1);
        chk("R6 rst held", core_rst, 1);
        wait_mode(0);
        chk("R6 running", core_clk_en, 1);

        // R9 clear
        cause_clr = 3'b001; idle(1); cause_clr = 3'b000;
        chk("R9 cleared", stat_cause, 0);

        // R7: requests during shutdown ignored
        vdd_flt = 1; idle(1); vdd_flt = 0;
        idle_req = 1; irq = 1; sleep_set = 1; ext_reset = 1; idle(2);
        idle_req = 0; irq = 0; sleep_set = 0; ext_reset = 0;
        chk("R7 still shutting", stat_mode, 2);
        chk("R7 cause vdd only", stat_cause, 3'b010);
        wait_mode(3);
        // R8 abort wake-up
        wake_evt = 1; idle(1); wake_evt = 0;
        batt_flt = 1; idle(1); batt_flt = 0;
        chk("R8 abort to shutdown", stat_mode, 2);
        chk("R8 cause battery", stat_cause, 3'b110);
        wait_mode(3);
        wake_evt = 1; idle(1); wake_evt = 0;
        irq = 1; idle_req = 1; idle(1); irq = 0; idle_req = 0;
        chk("R7 wake ignores requests", stat_mode, 4);
        wait_mode(0);

        // R9 set wins over clear
        cause_clr = 3'b111; batt_flt = 1; idle(1); cause_clr = 3'b000; batt_flt = 0;
        chk("R9 set beats clear", stat_cause, 3'b100);
        wait_mode(3);
        // R1 reset from sleep
        rst_n = 0; idle(2); rst_n = 1;
        chk("R1 reset from sleep mode", stat_mode, 0);
        chk("R1 reset from sleep supply", supply_en, 1);
        chk("R1 reset from sleep cause", stat_cause, 0);
        idle(3);
        report();
    end
endmodule